// File: doc/BRIEF.md
# External-data space router

This block sits between a small 8-bit microcontroller core and its external-data-memory accesses. It decides where each access goes. There are three places it can go: an internal 4 KB auxiliary RAM, an internal nonvolatile data region, or the external bus. It builds the full access address and the value driven onto port 2. It also tells the core how many cycles to wait before the access is done.

The core issues an access as a one-cycle request. The request gives the addressing kind: a 16-bit pointer, or an 8-bit register-indirect address whose upper byte comes from a page register. It also gives the address, the write strobe and the write data. Three control bits change the decode: one forces every access to the external bus, one marks in-application programming, and one enables the nonvolatile region. The page register is written through the special-function bus.

A write to the nonvolatile region holds the core stalled for a programmable number of cycles. For that whole time a busy flag is raised and interrupt servicing is blocked. Everything outside the core keeps running.

Top module: `xmem_router`

## Requirements
- R1: The page register is written only by an SFR write to address 86H and resets to 00H; SFR writes to any other address leave it unchanged.
- R2: When force_ext is 1, every access selects the external bus, whatever the addressing kind or address.
- R3: A 16-bit pointer access below 1000H selects the auxiliary RAM when iap is 0, and selects the external bus when iap is 1.
- R4: A 16-bit pointer access in 1000H–2FFFH selects the nonvolatile region only when iap is 0 and dmem_en is 1; otherwise it selects the external bus. Pointer accesses at 3000H and above select the external bus.
- R5: An 8-bit indirect access with page value below 10H selects the auxiliary RAM. With page 10H or above it selects the external bus. It never selects the nonvolatile region.
- R6: The port-2 value for an access is set by its kind and page: a pointer access drives address bits 15:8; an indirect access with page below 10H drives the page; an indirect access with page at 10H or above drives the latched port-2 SFR value. For an indirect access, mem_addr is {p2_out, address bits 7:0}; for a pointer access it is the pointer. While idle, p2_out follows p2_latch one cycle later.
- R7: From the clock edge that accepts a request until the access ends, exactly one of sel_aux, sel_nv, sel_ext is high, and core_wait is high. When no access is in progress, none of them is high.
- R8: core_wait stays high for 1 cycle for auxiliary RAM and external accesses, and for 3 cycles for nonvolatile reads. This makes each access 2, 2 and 4 cycles long, counting the request cycle.
- R9: A nonvolatile write holds core_wait, nv_busy and irq_hold high for nv_wr_len cycles, or for 1 cycle when nv_wr_len is 0. All three fall together when it ends.
- R10: mem_we and mem_wdata carry the request's write strobe and data from the accepting edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | One-cycle access request from the core |
| acc_wide | input | 1 | 1 = 16-bit pointer access, 0 = 8-bit indirect access |
| acc_addr | input | 16 | Access address (low byte only for indirect) |
| acc_we | input | 1 | Write strobe of the access |
| acc_wdata | input | 8 | Write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| p2_latch | input | 8 | Current port-2 SFR latch value |
| force_ext | input | 1 | Force every access to the external bus |
| iap | input | 1 | In-application-programming control bit |
| dmem_en | input | 1 | Nonvolatile data region enable |
| nv_wr_len | input | 16 | Stall length, in cycles, for nonvolatile writes |
| sel_aux | output | 1 | Auxiliary RAM selected |
| sel_nv | output | 1 | Nonvolatile region selected |
| sel_ext | output | 1 | External bus selected |
| mem_addr | output | 16 | Composed access address |
| mem_we | output | 1 | Registered write strobe |
| mem_wdata | output | 8 | Registered write data |
| p2_out | output | 8 | Port-2 drive value |
| core_wait | output | 1 | Stall to the core |
| nv_busy | output | 1 | Nonvolatile write in progress |
| irq_hold | output | 1 | Interrupt servicing blocked |

## Verification
The assertions assume the core never raises acc_req while core_wait is high. In real use a stalled core cannot issue a new access. The block ignores such a request, and the properties that begin with an accepted request rely on this rule. The stimulus keeps to it by starting each access only after core_wait has been seen low. Control bits and p2_latch change only between accesses. Addresses are chosen at random, but biased toward the 0FFFH/1000H and 2FFFH/3000H edges. Page values are biased toward 0FH/10H.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {
    RG_EXT = 2'd0,
    RG_AUX = 2'd1,
    RG_NV  = 2'd2
  } region_e;
endpackage

// File: rtl/xmem_page_reg.sv
module xmem_page_reg #(
  parameter int DW = 8,
  parameter int SW = 8,
  parameter logic [SW-1:0] SFR_ADDR = 8'h86
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sfr_we,
  input  logic [SW-1:0] sfr_addr,
  input  logic [DW-1:0] sfr_wdata,
  output logic [DW-1:0] page_q
);
  always_ff @(posedge clk) begin
    if (rst) page_q <= '0;
    else if (sfr_we && sfr_addr == SFR_ADDR) page_q <= sfr_wdata;
  end

  // R1: reset value
  a_r1_page_reset: assert property (@(posedge clk) rst |=> page_q == '0);
  // R1: only the own SFR address changes the register
  a_r1_page_hold: assert property (@(posedge clk) disable iff (rst)
    !(sfr_we && sfr_addr == SFR_ADDR) |=> $stable(page_q));
endmodule

// File: rtl/xmem_decode.sv
module xmem_decode
  import xmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int AUX_PAGES = 16,
  parameter logic [AW-1:0] NV_BASE  = 16'h1000,
  parameter logic [AW-1:0] NV_LIMIT = 16'h3000
) (
  input  logic          wide,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] page,
  input  logic [DW-1:0] p2_latch,
  input  logic          force_ext,
  input  logic          iap,
  input  logic          dmem_en,
  output region_e       region,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] p2_val
);
  localparam int LOW_W = AW - DW;
  localparam int PAGE_BYTES = 1 << LOW_W;
  localparam logic [AW-1:0] AUX_TOP = AW'(AUX_PAGES * PAGE_BYTES);
  localparam logic [DW-1:0] PAGE_LIM = DW'(AUX_PAGES);

  logic page_int, wide_aux, wide_nv;

  always_comb begin
    page_int = page < PAGE_LIM;
    wide_aux = !iap && addr < AUX_TOP;
    wide_nv  = !iap && dmem_en && addr >= NV_BASE && addr < NV_LIMIT;

    if (wide) p2_val = addr[AW-1:LOW_W];
    else if (page_int) p2_val = page;
    else p2_val = p2_latch;

    addr_out = wide ? addr : {p2_val, addr[LOW_W-1:0]};

    if (force_ext) region = RG_EXT;
    else if (wide && wide_aux) region = RG_AUX;
    else if (!wide && page_int) region = RG_AUX;
    else if (wide && wide_nv) region = RG_NV;
    else region = RG_EXT;
  end
endmodule

// File: rtl/xmem_stall.sv
module xmem_stall #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          running
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start) cnt <= load;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign running = cnt != '0;

  // R8 / R9: the stall count drains by one each cycle
  a_r8_count_down: assert property (@(posedge clk) disable iff (rst)
    running && !start |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/xmem_router.sv
module xmem_router
  import xmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SW = 8,
  parameter int CW = 16,
  parameter int AUX_PAGES = 16,
  parameter logic [AW-1:0] NV_BASE  = 16'h1000,
  parameter logic [AW-1:0] NV_LIMIT = 16'h3000,
  parameter logic [SW-1:0] PAGE_SFR = 8'h86,
  parameter int AUX_CYC = 2,
  parameter int EXT_CYC = 2,
  parameter int NV_RD_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_req,
  input  logic          acc_wide,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_we,
  input  logic [DW-1:0] acc_wdata,
  input  logic          sfr_we,
  input  logic [SW-1:0] sfr_addr,
  input  logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] p2_latch,
  input  logic          force_ext,
  input  logic          iap,
  input  logic          dmem_en,
  input  logic [CW-1:0] nv_wr_len,
  output logic          sel_aux,
  output logic          sel_nv,
  output logic          sel_ext,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] p2_out,
  output logic          core_wait,
  output logic          nv_busy,
  output logic          irq_hold
);
  localparam logic [CW-1:0] AUX_STALL = CW'(AUX_CYC - 1);
  localparam logic [CW-1:0] EXT_STALL = CW'(EXT_CYC - 1);
  localparam logic [CW-1:0] NVR_STALL = CW'(NV_RD_CYC - 1);
  localparam logic [DW-1:0] PAGE_LIM  = DW'(AUX_PAGES);

  logic [DW-1:0] page_q;
  region_e       dec_region, region_q;
  logic [AW-1:0] dec_addr;
  logic [DW-1:0] dec_p2;
  logic          running, start;
  logic [CW-1:0] stall_load;

  xmem_page_reg #(.DW(DW), .SW(SW), .SFR_ADDR(PAGE_SFR)) u_page (
    .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .page_q(page_q)
  );

  xmem_decode #(.AW(AW), .DW(DW), .AUX_PAGES(AUX_PAGES),
                .NV_BASE(NV_BASE), .NV_LIMIT(NV_LIMIT)) u_dec (
    .wide(acc_wide), .addr(acc_addr), .page(page_q), .p2_latch(p2_latch),
    .force_ext(force_ext), .iap(iap), .dmem_en(dmem_en),
    .region(dec_region), .addr_out(dec_addr), .p2_val(dec_p2)
  );

  assign start = acc_req && !running;

  always_comb begin
    unique case (dec_region)
      RG_AUX:  stall_load = AUX_STALL;
      RG_NV:   stall_load = acc_we ? ((nv_wr_len == '0) ? CW'(1) : nv_wr_len)
                                   : NVR_STALL;
      default: stall_load = EXT_STALL;
    endcase
  end

  xmem_stall #(.CW(CW)) u_stall (
    .clk(clk), .rst(rst), .start(start), .load(stall_load), .running(running)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q  <= RG_EXT;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      p2_out    <= '0;
    end else if (start) begin
      region_q  <= dec_region;
      mem_addr  <= dec_addr;
      mem_we    <= acc_we;
      mem_wdata <= acc_wdata;
      p2_out    <= dec_p2;
    end else if (!running) begin
      p2_out    <= p2_latch;
    end
  end

  assign core_wait = running;
  assign sel_aux   = running && region_q == RG_AUX;
  assign sel_nv    = running && region_q == RG_NV;
  assign sel_ext   = running && region_q == RG_EXT;
  assign nv_busy   = running && region_q == RG_NV && mem_we;
  assign irq_hold  = nv_busy;

  // R7: one select during an access
  a_r7_one_sel: assert property (@(posedge clk) disable iff (rst)
    core_wait |-> $countones({sel_aux, sel_nv, sel_ext}) == 1);
  // R7: nothing selected while idle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !core_wait |-> {sel_aux, sel_nv, sel_ext} == 3'b000);
  // R2: forced external access
  a_r2_forced_ext: assert property (@(posedge clk) disable iff (rst)
    start && force_ext |=> sel_ext);
  // R5: high page goes external with latched port 2
  a_r5_page_high: assert property (@(posedge clk) disable iff (rst)
    start && !acc_wide && page_q >= PAGE_LIM |=> sel_ext && p2_out == $past(p2_latch));
  // R5: indirect never reaches the nonvolatile region
  a_r5_no_nv_narrow: assert property (@(posedge clk) disable iff (rst)
    start && !acc_wide |=> !sel_nv);
  // R4: nonvolatile region gated by control bits
  a_r4_nv_gate: assert property (@(posedge clk) disable iff (rst)
    start && (iap || !dmem_en) |=> !sel_nv);
  // R9: busy implies stall and interrupt hold
  a_r9_busy_stall: assert property (@(posedge clk) disable iff (rst)
    nv_busy |-> core_wait && irq_hold);
  // R10: write data carried from the accepting edge
  a_r10_wdata: assert property (@(posedge clk) disable iff (rst)
    start |=> mem_wdata == $past(acc_wdata) && mem_we == $past(acc_we));
endmodule

// File: tb/xmem_router_bench.sv
module xmem_router_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_req = 0, acc_wide = 0, acc_we = 0;
  logic [15:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic sfr_we = 0;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0, p2_latch = '0;
  logic force_ext = 0, iap = 0, dmem_en = 0;
  logic [15:0] nv_wr_len = 16'd5;
  logic sel_aux, sel_nv, sel_ext, mem_we, core_wait, nv_busy, irq_hold;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, p2_out;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] page_m = 8'h00;

  always #4 clk = ~clk;

  xmem_router u_xmem_router (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_wide(acc_wide),
    .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .p2_latch(p2_latch), .force_ext(force_ext), .iap(iap), .dmem_en(dmem_en),
    .nv_wr_len(nv_wr_len), .sel_aux(sel_aux), .sel_nv(sel_nv), .sel_ext(sel_ext),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .p2_out(p2_out),
    .core_wait(core_wait), .nv_busy(nv_busy), .irq_hold(irq_hold)
  );

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // region codes: 1=aux 2=nv 4=ext as {nv? ...} packed {sel_ext,sel_nv,sel_aux}
  function automatic logic [2:0] exp_sel(input logic wide, input logic [15:0] a,
      input logic [7:0] pg, input logic fe, input logic ip, input logic de);
    if (fe) return 3'b100;                                           // R2
    if (wide && !ip && a < 16'h1000) return 3'b001;                  // R3
    if (!wide && pg < 8'h10) return 3'b001;                          // R5
    if (wide && !ip && de && a >= 16'h1000 && a < 16'h3000) return 3'b010; // R4
    return 3'b100;
  endfunction

  function automatic logic [7:0] exp_p2(input logic wide, input logic [15:0] a,
      input logic [7:0] pg, input logic [7:0] lat);
    if (wide) return a[15:8];                                        // R6
    if (pg < 8'h10) return pg;
    return lat;
  endfunction

  function automatic int exp_stall(input logic [2:0] s, input logic we, input logic [15:0] len);
    if (s == 3'b010) begin
      if (we) return (len == 0) ? 1 : int'(len);                     // R9
      return 3;                                                      // R8
    end
    return 1;                                                        // R8
  endfunction

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1; sfr_addr = a; sfr_wdata = d;
    if (a == 8'h86) page_m = d;
    @(negedge clk);
    sfr_we = 0;
  endtask

  task automatic access(input logic wide, input logic [15:0] a, input logic we,
      input logic [7:0] wd);
    logic [2:0] es;
    logic [7:0] ep;
    int n, en;
    bit nv_wr;
    es = exp_sel(wide, a, page_m, force_ext, iap, dmem_en);
    ep = exp_p2(wide, a, page_m, p2_latch);
    en = exp_stall(es, we, nv_wr_len);
    nv_wr = (es == 3'b010) && we;
    @(negedge clk);
    acc_req = 1; acc_wide = wide; acc_addr = a; acc_we = we; acc_wdata = wd;
    @(negedge clk);
    acc_req = 0;
    check("R7 select", {29'd0, sel_ext, sel_nv, sel_aux}, {29'd0, es});
    check("R6 port2", {24'd0, p2_out}, {24'd0, ep});
    check("R6 address", {16'd0, mem_addr}, {16'd0, wide ? a : {ep, a[7:0]}});
    check("R10 write", {23'd0, mem_we, mem_wdata}, {23'd0, we, wd});
    n = 0;
    while (core_wait && n < 70000) begin
      if (nv_wr) check("R9 busy", {30'd0, nv_busy, irq_hold}, 32'd3);
      n++;
      @(negedge clk);
    end
    check(nv_wr ? "R9 stall" : "R8 stall", n, en);
    check("R7 idle", {29'd0, sel_ext, sel_nv, sel_aux, nv_busy}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R7 reset sel", {29'd0, sel_ext, sel_nv, sel_aux}, 32'd0);
    check("R9 reset busy", {29'd0, core_wait, nv_busy, irq_hold}, 32'd0);
    rst = 0;
    @(negedge clk);

    // R1: page resets to 0 -> indirect goes to aux page 0
    p2_latch = 8'hA5;
    access(0, 16'h0042, 0, 8'h00);
    // R1: other SFR address does not change the page
    sfr_write(8'h87, 8'h33);
    access(0, 16'h0010, 0, 8'h00);
    sfr_write(8'h86, 8'h0F);
    access(0, 16'h00FF, 1, 8'h5A);
    sfr_write(8'h86, 8'h10);
    access(0, 16'h0001, 0, 8'h00);        // R5 page high -> external, port2 latch
    // R3/R4 edges
    dmem_en = 1;
    access(1, 16'h0FFF, 0, 8'h00);
    access(1, 16'h1000, 0, 8'h00);
    nv_wr_len = 16'd7;
    access(1, 16'h2FFF, 1, 8'hC3);        // R9
    nv_wr_len = 16'd0;
    access(1, 16'h1234, 1, 8'h11);        // R9 zero length
    access(1, 16'h3000, 0, 8'h00);
    iap = 1;
    access(1, 16'h0800, 0, 8'h00);        // R3 iap -> external
    access(1, 16'h1800, 0, 8'h00);        // R4 iap -> external
    access(0, 16'h0020, 0, 8'h00);
    iap = 0; force_ext = 1;
    access(1, 16'h0100, 0, 8'h00);        // R2
    access(1, 16'h1100, 1, 8'h00);        // R2
    force_ext = 0;
    // R6 idle: port2 follows latch
    @(negedge clk);
    p2_latch = 8'h3C;
    @(negedge clk);
    @(negedge clk);
    check("R6 idle port2", {24'd0, p2_out}, 32'h3C);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int sel;
      force_ext = ($urandom % 6) == 0;
      iap = ($urandom % 4) == 0;
      dmem_en = ($urandom % 3) != 0;
      p2_latch = 8'($urandom);
      nv_wr_len = 16'($urandom % 20);
      if (($urandom % 4) == 0) begin
        sel = $urandom % 4;
        if (sel == 0) sfr_write(8'h86, 8'h0F);
        else if (sel == 1) sfr_write(8'h86, 8'h10);
        else if (sel == 2) sfr_write(8'h86, 8'($urandom));
        else sfr_write(8'($urandom % 128), 8'($urandom));
      end
      sel = $urandom % 5;
      case (sel)
        0: a = 16'h0FFE + 16'($urandom % 4);
        1: a = 16'h2FFE + 16'($urandom % 4);
        2: a = 16'($urandom % 16'h4000);
        default: a = 16'($urandom);
      endcase
      access(1'($urandom), a, 1'($urandom), 8'($urandom));
    end
    finish_run();
  end
endmodule